// File: doc/BRIEF.md
# Jittered Reload Value Generator

This block produces a randomised reload value for a periodic timer. Each time the surrounding logic acknowledges a timer event it presents a nominal reload value, a width selection (16-bit or 32-bit timer) and a jitter percentage. The block adds a pseudo-random offset to the nominal value. The offset is scaled to the magnitude of the nominal value, so successive periods vary by roughly the requested fraction instead of by a fixed absolute amount.

The random source is a 32-bit shift register with inverted XOR feedback. It advances by one step for every acknowledge that requests jitter. The offset is taken from the register's contents before that step. The result is registered. A one-cycle valid pulse marks the cycle in which a fresh value is available. The value then holds until the next acknowledge.

Top module: `jitter_reload_gen`

## Requirements
- R1: After reset, `reload_o` is 0 and `valid_o` is 0. The random register holds 0xA690EA64, so the first jittered acknowledge uses that word.
- R2: One register step moves every bit up by one position. The new bit 0 is the complement of (bit 27 XOR bit 2).
- R3: The jitter percentage sets a base shift. A percentage of 1 to 6 gives 4, 7 to 13 gives 3, 14 to 25 gives 2, 26 to 50 gives 1, and above 50 gives 0.
- R4: An acknowledge with a percentage of 0 loads 0 into `reload_o` and leaves the random register unchanged.
- R5: With `wide_i` = 0, bits 15:0 of the register are read as a two's-complement number. This number is shifted right arithmetically by (base shift + 15 − L), where L is the leading-one position of `nominal_i[15:0]`. The result is added to `nominal_i[15:0]`.
- R6: In 16-bit mode, a sum that is negative or above 0xFFFF is replaced by 0xFFFF. Bits 31:16 of `reload_o` are always 0 in this mode.
- R7: With `wide_i` = 1, the full register is shifted right logically by (base shift + 31 − L), where L is the leading-one position of `nominal_i`. A shift of 32 or more gives 0. The result is added to `nominal_i` modulo 2^32.
- R8: A nominal value of 0 counts as leading-one position 0.
- R9: `valid_o` is 1 exactly in the cycle after each cycle with `ack_i` = 1, and 0 otherwise. `reload_o` changes only in the cycle after an acknowledge.
- R10: The offset for a jittered acknowledge comes from the register contents before the step that the same acknowledge causes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ack_i | input | 1 | Acknowledge strobe: compute a new reload value this cycle |
| wide_i | input | 1 | 1 selects 32-bit mode, 0 selects 16-bit mode |
| nominal_i | input | 32 | Nominal reload value |
| pct_i | input | 7 | Jitter percentage (0 disables jitter) |
| reload_o | output | 32 | Registered jittered reload value |
| valid_o | output | 1 | One-cycle pulse marking a new reload value |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 16-bit half mode, a 7-bit percentage and the stated seed. With these values the combined shift amount ranges from 0 to 35. This range includes shifts that push a 16-bit operand wholly into its sign bits and shifts that leave a 32-bit operand empty. A nominal value of 0 or 0xFFFF in 16-bit mode reaches both the negative-sum and the overflow sides of saturation. A long mixed stream of back-to-back and spaced acknowledges checks every step of the random register against the reference model.

// File: rtl/jrg_pkg.sv
package jrg_pkg;

  // Width of the percent-derived base shift (values 0..4).
  localparam int unsigned BASE_W = 3;

  // Upper percentage limits for each base shift.
  localparam int unsigned PCT_LIM_SH4 = 6;
  localparam int unsigned PCT_LIM_SH3 = 13;
  localparam int unsigned PCT_LIM_SH2 = 25;
  localparam int unsigned PCT_LIM_SH1 = 50;

  typedef logic [BASE_W-1:0] base_shift_t;

  // Coarse map from jitter percentage to base shift; the narrowest band wins.
  function automatic base_shift_t pct_base_shift(input int unsigned pct);
    base_shift_t sh;
    if (pct <= PCT_LIM_SH4)      sh = base_shift_t'(4);
    else if (pct <= PCT_LIM_SH3) sh = base_shift_t'(3);
    else if (pct <= PCT_LIM_SH2) sh = base_shift_t'(2);
    else if (pct <= PCT_LIM_SH1) sh = base_shift_t'(1);
    else                         sh = base_shift_t'(0);
    return sh;
  endfunction

endpackage

// File: rtl/jrg_lfsr.sv
module jrg_lfsr #(
  parameter int unsigned   W      = 32,
  parameter logic [W-1:0]  SEED   = 32'hA690EA64,
  parameter int unsigned   TAP_HI = 27,
  parameter int unsigned   TAP_LO = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  // Next state: shift up, feed back the inverted XOR of two taps.
  always_comb begin
    state_d = {state_q[W-2:0], ~(state_q[TAP_HI] ^ state_q[TAP_LO])};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (step_i) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/jrg_lead_one.sv
module jrg_lead_one #(
  parameter int unsigned W     = 32,
  parameter int unsigned POS_W = 5
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o
);

  // Priority encoder: the highest set bit wins; an all-zero input gives 0.
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = POS_W'(i);
    end
  end

endmodule

// File: rtl/jrg_offset.sv
module jrg_offset #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned SH_W   = 6
) (
  input  logic [WORD_W-1:0] rand_i,
  input  logic [WORD_W-1:0] nominal_i,
  input  logic              wide_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [WORD_W-1:0] result_o
);

  localparam int unsigned PAD_W = WORD_W - HALF_W;

  // Half mode: signed offset, two guard bits for saturation detection.
  logic signed [HALF_W-1:0] half_rand;
  logic signed [HALF_W-1:0] half_off;
  logic        [HALF_W+1:0] half_sum;
  logic                     half_sat;
  logic        [HALF_W-1:0] half_res;

  // Word mode: unsigned offset, wrap-around sum.
  logic [WORD_W-1:0] word_off;
  logic [WORD_W-1:0] word_sum;

  always_comb begin
    half_rand = rand_i[HALF_W-1:0];
    half_off  = half_rand >>> shamt_i;
    half_sum  = {2'b00, nominal_i[HALF_W-1:0]}
              + {{2{half_off[HALF_W-1]}}, half_off};
    half_sat  = |half_sum[HALF_W+1:HALF_W];
    half_res  = half_sat ? {HALF_W{1'b1}} : half_sum[HALF_W-1:0];
  end

  always_comb begin
    word_off = rand_i >> shamt_i;
    word_sum = nominal_i + word_off;
  end

  always_comb begin
    result_o = wide_i ? word_sum : {{PAD_W{1'b0}}, half_res};
  end

endmodule

// File: rtl/jitter_reload_gen.sv
module jitter_reload_gen
  import jrg_pkg::*;
#(
  parameter int unsigned       WORD_W = 32,
  parameter int unsigned       HALF_W = 16,
  parameter int unsigned       PCT_W  = 7,
  parameter logic [WORD_W-1:0] SEED   = 32'hA690EA64,
  parameter int unsigned       TAP_HI = 27,
  parameter int unsigned       TAP_LO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_i,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] nominal_i,
  input  logic [PCT_W-1:0]  pct_i,
  output logic [WORD_W-1:0] reload_o,
  output logic              valid_o
);

  localparam int unsigned POS_W = $clog2(WORD_W);
  localparam int unsigned SH_W  = POS_W + 1;
  localparam int unsigned PAD_W = WORD_W - HALF_W;

  logic [WORD_W-1:0] lfsr_q;
  logic              jitter_on;
  logic              step_en;
  base_shift_t       base_sh;
  logic [WORD_W-1:0] lead_vec;
  logic [POS_W-1:0]  lead_pos;
  logic [SH_W-1:0]   top_pos;
  logic [SH_W-1:0]   shamt;
  logic [WORD_W-1:0] jit_val;

  logic [WORD_W-1:0] reload_q, reload_d;
  logic              valid_q,  valid_d;

  // Control decode.
  always_comb begin
    jitter_on = (pct_i != '0);
    step_en   = ack_i & jitter_on;
    base_sh   = pct_base_shift(32'(pct_i));
  end

  jrg_lfsr #(
    .W      (WORD_W),
    .SEED   (SEED),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_en),
    .state_o (lfsr_q)
  );

  // Leading one of the operand actually used in the selected mode.
  always_comb begin
    lead_vec = wide_i ? nominal_i : {{PAD_W{1'b0}}, nominal_i[HALF_W-1:0]};
  end

  jrg_lead_one #(
    .W     (WORD_W),
    .POS_W (POS_W)
  ) u_lead (
    .vec_i (lead_vec),
    .pos_o (lead_pos)
  );

  // Shift amount: base + (top bit index - leading-one position).
  always_comb begin
    top_pos = wide_i ? SH_W'(WORD_W - 1) : SH_W'(HALF_W - 1);
    shamt   = SH_W'(base_sh) + top_pos - SH_W'(lead_pos);
  end

  jrg_offset #(
    .WORD_W (WORD_W),
    .HALF_W (HALF_W),
    .SH_W   (SH_W)
  ) u_offset (
    .rand_i    (lfsr_q),
    .nominal_i (nominal_i),
    .wide_i    (wide_i),
    .shamt_i   (shamt),
    .result_o  (jit_val)
  );

  // Output next state.
  always_comb begin
    reload_d = jitter_on ? jit_val : '0;
    valid_d  = ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
    end else if (ack_i) begin
      reload_q <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign reload_o = reload_q;
  assign valid_o  = valid_q;

endmodule

// File: rtl/jrg_checker.sv
module jrg_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PCT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_i,
  input logic              wide_i,
  input logic [PCT_W-1:0]  pct_i,
  input logic [WORD_W-1:0] reload_o,
  input logic              valid_o,
  input logic [WORD_W-1:0] lfsr_q
);

  // R9
  valid_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> valid_o);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !valid_o);

  // R9
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(reload_o));

  // R4
  zero_pct_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pct_i == '0) |=> (reload_o == '0));

  // R4
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && pct_i != '0) |=> $stable(lfsr_q));

  // R2
  lfsr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pct_i != '0) |=> (lfsr_q[WORD_W-1:1] == $past(lfsr_q[WORD_W-2:0])));

  // R6
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wide_i) |=> (reload_o[WORD_W-1:HALF_W] == '0));

endmodule

bind jitter_reload_gen jrg_checker #(
  .WORD_W (WORD_W),
  .HALF_W (HALF_W),
  .PCT_W  (PCT_W)
) u_jrg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_i    (ack_i),
  .wide_i   (wide_i),
  .pct_i    (pct_i),
  .reload_o (reload_o),
  .valid_o  (valid_o),
  .lfsr_q   (lfsr_q)
);

// File: tb/test_jitter_reload_gen.sv
`timescale 1ns/1ps
module test_jitter_reload_gen;

  logic        clk;
  logic        rst_n;
  logic        tb_ack;
  logic        tb_wide;
  logic [31:0] tb_nom;
  logic [6:0]  tb_pct;
  logic [31:0] reload_o;
  logic        valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit checking = 0;
  string cur_req = "R1";

  // Reference model state
  logic [31:0] m_rand;
  logic [31:0] exp_reload;
  bit          exp_valid;
  string       exp_req;

  jitter_reload_gen i_jitter_reload_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (tb_ack),
    .wide_i    (tb_wide),
    .nominal_i (tb_nom),
    .pct_i     (tb_pct),
    .reload_o  (reload_o),
    .valid_o   (valid_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int base_of(int p);
    if (p > 50) return 0;
    if (p > 25) return 1;
    if (p > 13) return 2;
    if (p > 6)  return 3;
    return 4;
  endfunction

  function automatic int top_one(logic [31:0] v, int hi);
    for (int i = hi; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] model_value(logic [31:0] rnd, bit wide,
                                              logic [31:0] nom, int pct);
    int sh;
    if (pct == 0) return 32'd0;
    if (wide) begin
      logic [31:0] off;
      sh  = base_of(pct) + 31 - top_one(nom, 31);
      off = (sh >= 32) ? 32'd0 : (rnd >> sh);
      return nom + off;
    end else begin
      int r, s, n;
      n  = int'(nom[15:0]);
      sh = base_of(pct) + 15 - top_one({16'd0, nom[15:0]}, 15);
      r  = int'($signed(rnd[15:0]));
      r  = r >>> sh;
      s  = n + r;
      if (s < 0 || s > 65535) s = 65535;
      return 32'(s);
    end
  endfunction

  // Cycle-level reference model, updated on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rand     = 32'hA690EA64;
      exp_reload = 32'd0;
      exp_valid  = 0;
      exp_req    = "R1";
    end else begin
      exp_valid = tb_ack;
      if (tb_ack) begin
        exp_req    = cur_req;
        exp_reload = model_value(m_rand, tb_wide, tb_nom, int'(tb_pct));
        if (tb_pct != 0) m_rand = {m_rand[30:0], ~(m_rand[27] ^ m_rand[2])};
      end
    end
  end

  // Compare away from the active edge, every cycle.
  always @(negedge clk) begin
    if (checking && !done) begin
      checks++;
      if (reload_o !== exp_reload) begin
        fails++;
        $display("FAIL %s reload_o got %h expected %h at %0t", exp_req, reload_o, exp_reload, $time);
      end
      checks++;
      if (valid_o !== exp_valid) begin
        fails++;
        $display("FAIL R9 valid_o got %b expected %b at %0t", valid_o, exp_valid, $time);
      end
    end
  end

  task automatic drive(bit ack, bit wide, logic [31:0] nom, int pct, string req);
    @(negedge clk);
    tb_ack  = ack;
    tb_wide = wide;
    tb_nom  = nom;
    tb_pct  = 7'(pct);
    cur_req = req;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, tb_wide, tb_nom, int'(tb_pct), "R9");
  endtask

  initial begin
    tb_ack = 0; tb_wide = 0; tb_nom = 0; tb_pct = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (reload_o !== 32'd0 || valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs got %h/%b expected 0/0", reload_o, valid_o);
    end
    rst_n = 1;
    checking = 1;

    // R1/R10: first jittered value uses the seed word
    drive(1, 1, 32'h0001_0000, 60, "R1");
    drive(0, 1, 32'h0001_0000, 60, "R9");
    idle(2);
    // R2: consecutive steps seen through word mode with no base shift
    drive(1, 1, 32'h8000_0000, 100, "R2");
    drive(1, 1, 32'h8000_0000, 100, "R2");
    drive(1, 1, 32'h4000_0000, 51, "R2");
    // R3: every band boundary, 16-bit mode
    drive(1, 0, 32'h0000_4000, 1,  "R3");
    drive(1, 0, 32'h0000_4000, 6,  "R3");
    drive(1, 0, 32'h0000_4000, 7,  "R3");
    drive(1, 0, 32'h0000_4000, 13, "R3");
    drive(1, 0, 32'h0000_4000, 14, "R3");
    drive(1, 0, 32'h0000_4000, 25, "R3");
    drive(1, 0, 32'h0000_4000, 26, "R3");
    drive(1, 0, 32'h0000_4000, 50, "R3");
    drive(1, 0, 32'h0000_4000, 51, "R3");
    idle(1);
    // R4/R10: zero percent gives 0 and the following value is unperturbed
    drive(1, 1, 32'h1234_5678, 0, "R4");
    drive(1, 0, 32'h0000_1234, 0, "R4");
    drive(1, 1, 32'h1234_5678, 90, "R10");
    idle(1);
    // R5: small and large 16-bit nominals, upper input bits ignored
    drive(1, 0, 32'hFFFF_0003, 70, "R5");
    drive(1, 0, 32'h0000_0100, 30, "R5");
    drive(1, 0, 32'hABCD_7FFF, 20, "R5");
    // R6: saturation high and from negative sums
    drive(1, 0, 32'h0000_FFFF, 100, "R6");
    drive(1, 0, 32'h0000_FFFE, 100, "R6");
    drive(1, 0, 32'h0000_0000, 100, "R6");
    drive(1, 0, 32'h0000_0001, 100, "R6");
    // R7: wrap-around and large shifts in word mode
    drive(1, 1, 32'hFFFF_FFF0, 80, "R7");
    drive(1, 1, 32'h0000_0001, 3,  "R7");
    // R8: zero nominal in both modes
    drive(1, 1, 32'h0000_0000, 2, "R8");
    drive(1, 0, 32'h0000_0000, 2, "R8");
    drive(1, 1, 32'h0000_0000, 99, "R8");
    idle(3);

    // Mixed stream
    for (int k = 0; k < 600; k++) begin
      int pc;
      logic [31:0] nv;
      case ($urandom % 8)
        0: pc = 0;
        1: pc = 1 + ($urandom % 6);
        2: pc = 7 + ($urandom % 7);
        3: pc = 14 + ($urandom % 12);
        4: pc = 26 + ($urandom % 25);
        default: pc = 51 + ($urandom % 77);
      endcase
      nv = $urandom >> ($urandom % 33);
      drive(($urandom % 3) != 0, $urandom % 2, nv, pc, "R5");
    end
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      done = 1;
      $display("FAIL R9 watchdog expired got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule